// File: doc/BRIEF.md
# Interrupt Priority Masking and Preemption Selector

This block looks at a vector of interrupt request lines, each with a pending flag and an enable flag supplied from outside, and finds the most urgent request that is both pending and enabled. It then decides whether that request may interrupt the code now running. The result is a registered take signal and the exception number of the chosen request. Exception numbers start at 16 for line 0.

Each line has a priority byte, and a smaller value means more urgent. Only the upper bits of the byte are stored. A three-bit group setting splits the byte into a preempt field (upper part) and a subpriority field (lower part). The choice of winner uses the whole stored byte. The decision to preempt uses only the preempt field.

Three masks raise the effective running level:
- A global disable bit.
- A fault-level disable bit, which clears itself when an exception returns.
- A threshold byte. It can be written directly, or through a conditional port that only tightens it.

All three masks can be written only while the privileged input is high.

Top module: `irq_preempt_sel`

## Requirements
- R1: After reset, every priority byte reads 0, the threshold reads 0, both disable bits read 0, and take is low.
- R2: A priority byte keeps only its upper PRIO_BITS bits and the lower bits read as 0. With PRIO_BITS = 3, writing 0xFF reads back 0xE0 and writing 0x5A reads back 0x40.
- R3: Among lines that are both pending and enabled, the lowest stored priority wins. When two lines tie, the lower line number wins. exc_num_o equals 16 plus the winning line number.
- R4: The group value g (0..7) makes bits 7 down to g+1 the preempt field. Take is high only when the winner's preempt field is strictly below the preempt field of run_prio_i. This applies while run_active_i is high. With run_active_i low, any winner is taken.
- R5: While the global disable bit is 1 (mask select 0, data bit 0), take stays low.
- R6: While the fault-level disable bit is 1 (mask select 1, data bit 0), take stays low. An exception exit clears the bit unless exit_nmi_i is high during that exit.
- R7: A nonzero threshold (mask select 2) blocks any winner whose preempt field is equal to or above the threshold's preempt field. A threshold of 0 blocks nothing.
- R8: A write through the conditional threshold port (mask select 3) is stored only when the truncated value is nonzero and either the threshold is 0 or the new value is lower than the current threshold. Otherwise the write is dropped.
- R9: Mask writes made while priv_i is low change nothing.
- R10: take_o and exc_num_o are registered. They reflect the inputs and state one clock edge later. exc_num_o reads 0 whenever take_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | High when the current access is privileged |
| irq_pend_i | input | N_IRQ | Pending flag for each line |
| irq_en_i | input | N_IRQ | Enable flag for each line |
| prio_we_i | input | 1 | Priority byte write strobe |
| prio_idx_i | input | IDX_W | Line index used for both write and read |
| prio_wdata_i | input | 8 | Priority byte to write |
| prio_rdata_o | output | 8 | Stored priority byte of line prio_idx_i |
| group_we_i | input | 1 | Group setting write strobe |
| group_wdata_i | input | 3 | New group setting |
| msk_we_i | input | 1 | Mask write strobe |
| msk_sel_i | input | 2 | Mask target: 0 global disable, 1 fault disable, 2 threshold, 3 conditional threshold |
| msk_wdata_i | input | 8 | Mask write data |
| exc_exit_i | input | 1 | Pulse when an exception returns |
| exit_nmi_i | input | 1 | High when that return is from the non-maskable handler |
| run_active_i | input | 1 | High while an exception handler is running |
| run_prio_i | input | 8 | Priority of the running handler |
| gdis_o | output | 1 | Global disable bit |
| fdis_o | output | 1 | Fault-level disable bit |
| thresh_o | output | 8 | Threshold value |
| take_o | output | 1 | The winning request may preempt |
| exc_num_o | output | 8 | Exception number of the taken request |

## Verification
The hardest case to reach is the one where the group setting changes the preempt decision without changing the winner. The bench reaches it by holding one request at 0x40 against a running handler at 0x60. With group 0 the request is taken. With group 5 both values share the preempt field 0x40, so the request is held back.

The conditional threshold port needs a fixed sequence to test its accept and drop rules:
- A weaker value, which must be dropped.
- A stronger value, which must be stored.
- A zero, which must be dropped.
- A write made while the threshold is 0, which must be stored.

After each write the bench reads the threshold back.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int EXC_BASE = 16;

    typedef enum logic [1:0] {
        MSK_GDIS   = 2'd0,
        MSK_FDIS   = 2'd1,
        MSK_THR    = 2'd2,
        MSK_THRMAX = 2'd3
    } msk_sel_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] idx;
        logic [7:0] prio;
    } winner_t;

    // Bits of a priority byte that are actually stored.
    function automatic logic [7:0] keep_mask(input int bits);
        return 8'hFF << (8 - bits);
    endfunction

    // Bits that form the preempt field under group setting g.
    function automatic logic [7:0] preempt_mask(input logic [2:0] g);
        logic [7:0] m;
        m = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            if (i <= int'(g)) m[i] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_prio_store.sv
module irq_prio_store #(
    parameter int N_IRQ     = 8,
    parameter int PRIO_BITS = 3,
    localparam int IDX_W    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output logic [N_IRQ-1:0][7:0]  prio_all
);
    import irq_sel_pkg::*;

    localparam logic [7:0] KEEP = keep_mask(PRIO_BITS);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= 8'h00;
            end else if (we && (int'(idx) == i)) begin
                slot_q <= wdata & KEEP;
            end
        end
        assign prio_all[i] = slot_q;
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < N_IRQ; i++) begin
            if (int'(idx) == i) rdata = prio_all[i];
        end
    end
endmodule

// File: rtl/irq_winner.sv
module irq_winner #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0]       pend,
    input  logic [N_IRQ-1:0]       en,
    input  logic [N_IRQ-1:0][7:0]  prio_all,
    output irq_sel_pkg::winner_t   win
);
    import irq_sel_pkg::*;

    always_comb begin
        win = '0;
        // Strict compare keeps the lower index on a tie.
        for (int i = 0; i < N_IRQ; i++) begin
            if (pend[i] && en[i] && (!win.valid || prio_all[i] < win.prio)) begin
                win.valid = 1'b1;
                win.idx   = 8'(i);
                win.prio  = prio_all[i];
            end
        end
    end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
    parameter int PRIO_BITS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       priv,
    input  logic       we,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    input  logic       exc_exit,
    input  logic       exit_nmi,
    output logic       gdis,
    output logic       fdis,
    output logic [7:0] thr
);
    import irq_sel_pkg::*;

    localparam logic [7:0] KEEP = keep_mask(PRIO_BITS);

    logic       wr_ok;
    logic [7:0] w_trunc;
    logic       max_ok;

    assign wr_ok   = we && priv;
    assign w_trunc = wdata & KEEP;
    assign max_ok  = (w_trunc != 8'h00) && ((thr == 8'h00) || (w_trunc < thr));

    always_ff @(posedge clk) begin
        if (rst) begin
            gdis <= 1'b0;
            fdis <= 1'b0;
            thr  <= 8'h00;
        end else begin
            if (exc_exit && !exit_nmi) fdis <= 1'b0;
            if (wr_ok) begin
                unique case (msk_sel_e'(sel))
                    MSK_GDIS:   gdis <= wdata[0];
                    MSK_FDIS:   fdis <= wdata[0];
                    MSK_THR:    thr  <= w_trunc;
                    MSK_THRMAX: if (max_ok) thr <= w_trunc;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_preempt_sel.sv
module irq_preempt_sel #(
    parameter int N_IRQ     = 8,
    parameter int PRIO_BITS = 3,
    localparam int IDX_W    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             priv_i,
    input  logic [N_IRQ-1:0] irq_pend_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic             prio_we_i,
    input  logic [IDX_W-1:0] prio_idx_i,
    input  logic [7:0]       prio_wdata_i,
    output logic [7:0]       prio_rdata_o,
    input  logic             group_we_i,
    input  logic [2:0]       group_wdata_i,
    input  logic             msk_we_i,
    input  logic [1:0]       msk_sel_i,
    input  logic [7:0]       msk_wdata_i,
    input  logic             exc_exit_i,
    input  logic             exit_nmi_i,
    input  logic             run_active_i,
    input  logic [7:0]       run_prio_i,
    output logic             gdis_o,
    output logic             fdis_o,
    output logic [7:0]       thresh_o,
    output logic             take_o,
    output logic [7:0]       exc_num_o
);
    import irq_sel_pkg::*;

    localparam logic [7:0] KEEP = keep_mask(PRIO_BITS);
    localparam int THREAD_LVL   = 256;

    logic [N_IRQ-1:0][7:0] prio_all;
    winner_t               win;
    logic [2:0]            group_q;
    logic [7:0]            pmask;
    int                    eff_lvl;
    logic                  take_d;

    irq_prio_store #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (prio_we_i),
        .idx      (prio_idx_i),
        .wdata    (prio_wdata_i),
        .rdata    (prio_rdata_o),
        .prio_all (prio_all)
    );

    irq_winner #(.N_IRQ(N_IRQ)) u_win (
        .pend     (irq_pend_i),
        .en       (irq_en_i),
        .prio_all (prio_all),
        .win      (win)
    );

    irq_mask_regs #(.PRIO_BITS(PRIO_BITS)) u_masks (
        .clk      (clk),
        .rst      (rst),
        .priv     (priv_i),
        .we       (msk_we_i),
        .sel      (msk_sel_i),
        .wdata    (msk_wdata_i),
        .exc_exit (exc_exit_i),
        .exit_nmi (exit_nmi_i),
        .gdis     (gdis_o),
        .fdis     (fdis_o),
        .thr      (thresh_o)
    );

    always_ff @(posedge clk) begin
        if (rst)             group_q <= 3'd0;
        else if (group_we_i) group_q <= group_wdata_i;
    end

    assign pmask = preempt_mask(group_q);

    // Effective running level: 256 = thread, -1 = fault-level masked.
    always_comb begin
        eff_lvl = run_active_i ? int'(run_prio_i & KEEP & pmask) : THREAD_LVL;
        if ((thresh_o != 8'h00) && (int'(thresh_o & pmask) < eff_lvl))
            eff_lvl = int'(thresh_o & pmask);
        if (gdis_o) eff_lvl = 0;
        if (fdis_o) eff_lvl = -1;
        take_d = win.valid && (int'(win.prio & pmask) < eff_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o    <= 1'b0;
            exc_num_o <= 8'h00;
        end else begin
            take_o    <= take_d;
            exc_num_o <= take_d ? 8'(EXC_BASE + int'(win.idx)) : 8'h00;
        end
    end
endmodule

// File: rtl/irq_preempt_sel_chk.sv
module irq_preempt_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       priv_i,
    input logic       msk_we_i,
    input logic [1:0] msk_sel_i,
    input logic       exc_exit_i,
    input logic       exit_nmi_i,
    input logic       gdis_o,
    input logic       fdis_o,
    input logic [7:0] thresh_o,
    input logic       take_o,
    input logic [7:0] exc_num_o
);
    assert_gdis_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        gdis_o |=> !take_o);

    assert_fdis_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        fdis_o |=> !take_o);

    assert_fdis_exit_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (exc_exit_i && !exit_nmi_i && !(msk_we_i && priv_i && msk_sel_i == 2'd1))
        |=> !fdis_o);

    assert_thrmax_tightens_R8: assert property (@(posedge clk) disable iff (rst)
        (msk_we_i && priv_i && msk_sel_i == 2'd3 && thresh_o != 8'h00 && !exc_exit_i)
        |=> (thresh_o <= $past(thresh_o)));

    assert_user_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (msk_we_i && !priv_i && !exc_exit_i)
        |=> ($stable(thresh_o) && $stable(gdis_o) && $stable(fdis_o)));

    assert_excnum_base_R10: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (exc_num_o >= 8'd16));
endmodule

bind irq_preempt_sel irq_preempt_sel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .priv_i     (priv_i),
    .msk_we_i   (msk_we_i),
    .msk_sel_i  (msk_sel_i),
    .exc_exit_i (exc_exit_i),
    .exit_nmi_i (exit_nmi_i),
    .gdis_o     (gdis_o),
    .fdis_o     (fdis_o),
    .thresh_o   (thresh_o),
    .take_o     (take_o),
    .exc_num_o  (exc_num_o)
);

// File: tb/sim_irq_preempt_sel.sv
module sim_irq_preempt_sel;
    localparam int N = 8;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic priv_i = 1'b1;
    logic [N-1:0] irq_pend_i = '0;
    logic [N-1:0] irq_en_i = '0;
    logic prio_we_i = 1'b0;
    logic [2:0] prio_idx_i = '0;
    logic [7:0] prio_wdata_i = '0;
    logic [7:0] prio_rdata_o;
    logic group_we_i = 1'b0;
    logic [2:0] group_wdata_i = '0;
    logic msk_we_i = 1'b0;
    logic [1:0] msk_sel_i = '0;
    logic [7:0] msk_wdata_i = '0;
    logic exc_exit_i = 1'b0;
    logic exit_nmi_i = 1'b0;
    logic run_active_i = 1'b0;
    logic [7:0] run_prio_i = '0;
    logic gdis_o, fdis_o, take_o;
    logic [7:0] thresh_o, exc_num_o;

    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_preempt_sel #(.N_IRQ(N), .PRIO_BITS(P)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_prio(input int idx, input logic [7:0] v);
        prio_idx_i = 3'(idx); prio_wdata_i = v; prio_we_i = 1'b1;
        @(posedge clk); @(negedge clk);
        prio_we_i = 1'b0;
    endtask

    task automatic wr_group(input logic [2:0] g);
        group_wdata_i = g; group_we_i = 1'b1;
        @(posedge clk); @(negedge clk);
        group_we_i = 1'b0;
    endtask

    task automatic wr_msk(input logic [1:0] sel, input logic [7:0] v);
        msk_sel_i = sel; msk_wdata_i = v; msk_we_i = 1'b1;
        @(posedge clk); @(negedge clk);
        msk_we_i = 1'b0;
    endtask

    task automatic do_exit(input logic nmi);
        exit_nmi_i = nmi; exc_exit_i = 1'b1;
        @(posedge clk); @(negedge clk);
        exc_exit_i = 1'b0; exit_nmi_i = 1'b0;
    endtask

    task automatic all_prio(input logic [7:0] v);
        for (int i = 0; i < N; i++) wr_prio(i, v);
    endtask

    task automatic t_reset();
        chk("R1 take", int'(take_o), 0);
        chk("R1 thresh", int'(thresh_o), 0);
        chk("R1 gdis", int'(gdis_o), 0);
        chk("R1 fdis", int'(fdis_o), 0);
        for (int i = 0; i < N; i++) begin
            prio_idx_i = 3'(i); #1;
            chk("R1 prio", int'(prio_rdata_o), 0);
        end
    endtask

    task automatic t_trunc();
        wr_prio(1, 8'hFF); prio_idx_i = 3'd1; #1;
        chk("R2 ff", int'(prio_rdata_o), 'hE0);
        wr_prio(1, 8'h5A); prio_idx_i = 3'd1; #1;
        chk("R2 5a", int'(prio_rdata_o), 'h40);
        wr_prio(1, 8'h00);
    endtask

    task automatic t_winner();
        irq_en_i = '1; irq_pend_i = '1; settle();
        chk("R3 tie all zero take", int'(take_o), 1);
        chk("R3 tie all zero num", int'(exc_num_o), 16);
        all_prio(8'hA0);
        wr_prio(5, 8'h20); wr_prio(6, 8'h20); wr_prio(3, 8'h40);
        irq_pend_i = 8'b0110_1000; settle();
        chk("R3 lowest tie idx5", int'(exc_num_o), 21);
        irq_en_i = 8'b1101_1111; settle();
        chk("R3 masked en idx6", int'(exc_num_o), 22);
        irq_en_i = '1; irq_pend_i = 8'b0000_1000; settle();
        chk("R3 single idx3", int'(exc_num_o), 19);
        irq_en_i = '0; settle();
        chk("R10 no take", int'(take_o), 0);
        chk("R10 num zero", int'(exc_num_o), 0);
        irq_en_i = '1; irq_pend_i = '0;
    endtask

    task automatic t_group();
        all_prio(8'hE0); wr_prio(4, 8'h40);
        irq_pend_i = 8'b0001_0000;
        run_active_i = 1'b1; run_prio_i = 8'h60;
        wr_group(3'd0); settle();
        chk("R4 g0 preempt", int'(take_o), 1);
        chk("R4 g0 num", int'(exc_num_o), 20);
        wr_group(3'd5); settle();
        chk("R4 g5 same preempt field", int'(take_o), 0);
        wr_prio(4, 8'h20); settle();
        chk("R4 g5 lower field", int'(take_o), 1);
        run_active_i = 1'b0; wr_group(3'd0);
        irq_pend_i = '0;
    endtask

    task automatic t_thresh();
        all_prio(8'hE0); wr_prio(4, 8'h60);
        irq_pend_i = 8'b0001_0000; settle();
        chk("R7 thread take", int'(take_o), 1);
        wr_msk(2'd2, 8'h60); settle();
        chk("R7 equal blocked", int'(take_o), 0);
        wr_prio(4, 8'h40); settle();
        chk("R7 below passes", int'(take_o), 1);
        wr_prio(4, 8'h60); wr_msk(2'd2, 8'h00); settle();
        chk("R7 zero off", int'(take_o), 1);
        irq_pend_i = '0;
    endtask

    task automatic t_thrmax();
        wr_msk(2'd2, 8'h60);
        wr_msk(2'd3, 8'hF0); settle();
        chk("R8 weaker dropped", int'(thresh_o), 'h60);
        wr_msk(2'd3, 8'h40); settle();
        chk("R8 stronger kept", int'(thresh_o), 'h40);
        wr_msk(2'd3, 8'h00); settle();
        chk("R8 zero dropped", int'(thresh_o), 'h40);
        wr_msk(2'd2, 8'h00);
        wr_msk(2'd3, 8'hE0); settle();
        chk("R8 from zero", int'(thresh_o), 'hE0);
        wr_msk(2'd2, 8'h00);
    endtask

    task automatic t_gdis();
        all_prio(8'h00); irq_pend_i = 8'b0000_0100; settle();
        chk("R5 before", int'(take_o), 1);
        wr_msk(2'd0, 8'h01); settle();
        chk("R5 blocked", int'(take_o), 0);
        wr_msk(2'd0, 8'h00); settle();
        chk("R5 released", int'(take_o), 1);
    endtask

    task automatic t_fdis();
        wr_msk(2'd1, 8'h01); settle();
        chk("R6 blocked", int'(take_o), 0);
        do_exit(1'b1); settle();
        chk("R6 nmi exit keeps", int'(fdis_o), 1);
        do_exit(1'b0); settle();
        chk("R6 exit clears", int'(fdis_o), 0);
        chk("R6 take again", int'(take_o), 1);
    endtask

    task automatic t_priv();
        priv_i = 1'b0;
        wr_msk(2'd2, 8'h20);
        wr_msk(2'd0, 8'h01);
        wr_msk(2'd3, 8'h20); settle();
        chk("R9 thresh", int'(thresh_o), 0);
        chk("R9 gdis", int'(gdis_o), 0);
        chk("R9 take", int'(take_o), 1);
        priv_i = 1'b1; irq_pend_i = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trunc();
        t_winner();
        t_group();
        t_thresh();
        t_thrmax();
        t_gdis();
        t_fdis();
        t_priv();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule